// File: doc/BRIEF.md
# Parallel ADC Conversion Sequencer

This block runs one conversion at a time on a 14-bit sampling converter that has a parallel output bus, and hands each result to the host logic. A start request opens the acquisition window by pulling the active-low conversion-start line low for a fixed number of system clock cycles. When the window closes, the block waits a short setup gap and then drives exactly sixteen conversion clock pulses. It then waits for the converter's active-low end-of-conversion strobe. On that strobe it lowers chip select and read together, samples the data bus at the end of the read window, and waits for the bus to be released. Only then does it offer the word on a valid/ready output.

Every interval is a parameter counted in system clock cycles. These are the acquisition length, the setup gap, the half period of the conversion clock, the read strobe width, the bus release gap and the end-of-conversion timeout. If end of conversion does not come in time, a one-cycle timeout flag is raised and the block goes back to idle. The end-of-conversion input is treated as asynchronous and passes through a two-stage synchronizer.

Top module: `adc_conv_ctrl`

## Requirements
- R1: After a synchronous reset, and while reset is held, conv_start_n_o, cs_n_o and rd_n_o are 1 and conv_clk_o, res_valid_o, timeout_o and busy_o are 0.
- R2: A start_i sampled high while idle drives conv_start_n_o low for exactly ACQ_CYC cycles (default 8), after which it returns high.
- R3: The first conversion clock rising edge comes SETUP_CYC cycles (default 2) after conv_start_n_o rises. Exactly N_CONV_CLK pulses (default 16) follow, each high for HALF_CYC cycles and low for HALF_CYC cycles between pulses (default 3).
- R4: A falling edge on eoc_n_i during the conversion phase pulls cs_n_o and rd_n_o low together 3 cycles after the edge at which eoc_n_i was first low. Both stay low for RD_CYC cycles (default 3) and rise together. An end-of-conversion strobe while idle starts no read.
- R5: The value on data_i in the last cycle of the read window is the value later shown on res_data_o.
- R6: res_valid_o rises exactly REL_CYC cycles (default 2) after rd_n_o rises. No new acquisition begins before then.
- R7: While res_valid_o is 1 and res_ready_i is 0, res_valid_o and res_data_o hold. res_valid_o falls on the edge after the cycle in which res_ready_i is 1, so a delay of d cycles before ready gives d+1 valid cycles.
- R8: start_i pulses while busy_o is 1 have no effect: one conversion gives one conversion-start low pulse, with unchanged timing.
- R9: If no end of conversion comes within TIMEOUT_CYC cycles (default 200) of the first conversion clock edge, timeout_o is 1 for one cycle exactly TIMEOUT_CYC cycles after that edge. busy_o is 0 from then on, and no read or valid result follows.
- R10: conv_clk_o is 0 whenever conv_start_n_o or rd_n_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Conversion request, sampled only while idle |
| conv_start_n_o | output | 1 | Conversion start to converter, low during acquisition |
| conv_clk_o | output | 1 | Generated conversion clock |
| cs_n_o | output | 1 | Active-low chip select |
| rd_n_o | output | 1 | Active-low read strobe |
| eoc_n_i | input | 1 | Active-low end-of-conversion strobe (asynchronous) |
| data_i | input | 14 | Converter data bus |
| res_data_o | output | 14 | Captured result |
| res_valid_o | output | 1 | Result valid |
| res_ready_i | input | 1 | Host accepts the result |
| timeout_o | output | 1 | One-cycle pulse when end of conversion is missing |
| busy_o | output | 1 | A conversion sequence is in progress |

## Verification
The assertions check on every cycle that the conversion clock is quiet during acquisition and reading, and that a read strobe only follows a detected end-of-conversion edge. They also check that a held result does not change while it waits for ready, that a timeout leaves the block idle, that the start line stays high right after the bus is released, and that the pulse counter never passes its limit. Only the bench scenarios can show the exact interval lengths, the total pulse count, the captured word against the bus value, ignored start requests, and recovery from a reset taken in mid-conversion.

// File: rtl/adc_conv_pkg.sv
// Package: shared state encoding and helper functions for the conversion
// sequencer. Assumes nothing beyond elaboration-time constant evaluation.
package adc_conv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ACQ     = 3'd1,
        ST_SETUP   = 3'd2,
        ST_CONV    = 3'd3,
        ST_READ    = 3'd4,
        ST_REL     = 3'd5,
        ST_PRESENT = 3'd6
    } ctrl_state_t;

    // Larger of two integers, for deriving counter widths.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_step_timer.sv
// Module: loadable down-counter shared by every timed phase of the sequencer.
// Assumes: load has priority; done is high while the count is zero, so a
// phase loaded with N-1 lasts exactly N cycles.
module adc_step_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt_q;

    // Load a new interval or count toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/adc_conv_clk_gen.sv
// Module: produces a burst of N_PULSES conversion clock pulses, each high
// and low for HALF_CYC system cycles, starting high on the go cycle edge.
// Assumes: go is a one-cycle pulse; dropping en aborts the burst at once.
module adc_conv_clk_gen #(
    parameter int HALF_CYC = 3,
    parameter int N_PULSES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic en,
    output logic conv_clk_o
);

    localparam int DIV_W  = $clog2(HALF_CYC + 1);
    localparam int PCNT_W = $clog2(N_PULSES + 1);

    logic              running_q;
    logic              clk_q;
    logic [DIV_W-1:0]  div_q;
    logic [PCNT_W-1:0] pcnt_q;

    // Burst sequencer: phase divider plus count of completed pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            clk_q     <= 1'b0;
            div_q     <= '0;
            pcnt_q    <= '0;
        end else if (go) begin
            running_q <= 1'b1;
            clk_q     <= 1'b1;
            div_q     <= DIV_W'(HALF_CYC - 1);
            pcnt_q    <= '0;
        end else if (!en) begin
            running_q <= 1'b0;
            clk_q     <= 1'b0;
            div_q     <= '0;
        end else if (running_q) begin
            if (div_q != '0) begin
                div_q <= div_q - 1'b1;
            end else if (clk_q) begin
                clk_q  <= 1'b0;
                div_q  <= DIV_W'(HALF_CYC - 1);
                pcnt_q <= pcnt_q + 1'b1;
            end else if (pcnt_q < PCNT_W'(N_PULSES)) begin
                clk_q <= 1'b1;
                div_q <= DIV_W'(HALF_CYC - 1);
            end else begin
                running_q <= 1'b0;
            end
        end
    end

    assign conv_clk_o = clk_q;

    // R3: the burst never counts past its pulse limit.
    p_pulse_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt_q <= PCNT_W'(N_PULSES));

endmodule

// File: rtl/adc_conv_ctrl.sv
// Module: top of the conversion sequencer. It walks acquisition, setup,
// clocked conversion, read, bus release and result hand-off, with all
// intervals in system clock cycles.
// Assumes: eoc_n_i is asynchronous (two-stage synchronizer); data_i is
// stable by the last read cycle when RD_CYC covers the bus access time.
module adc_conv_ctrl #(
    parameter int DATA_W      = 14,
    parameter int ACQ_CYC     = 8,
    parameter int SETUP_CYC   = 2,
    parameter int HALF_CYC    = 3,
    parameter int N_CONV_CLK  = 16,
    parameter bit EXT_CLK     = 1'b1,
    parameter int RD_CYC      = 3,
    parameter int REL_CYC     = 2,
    parameter int TIMEOUT_CYC = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              conv_start_n_o,
    output logic              conv_clk_o,
    output logic              cs_n_o,
    output logic              rd_n_o,
    input  logic              eoc_n_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] res_data_o,
    output logic              res_valid_o,
    input  logic              res_ready_i,
    output logic              timeout_o,
    output logic              busy_o
);
    import adc_conv_pkg::*;

    localparam int MAX_CYC = max2(max2(max2(ACQ_CYC, SETUP_CYC), max2(RD_CYC, REL_CYC)),
                                  TIMEOUT_CYC);
    localparam int TMR_W   = $clog2(MAX_CYC + 1);

    ctrl_state_t       state_q, state_d;
    logic              eoc_s1_q, eoc_s2_q, eoc_s3_q;
    logic              eoc_fall_w;
    logic              tmr_done, tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              timeout_d;
    logic              clk_go, clk_en;
    logic              conv_start_n_q, cs_n_q, rd_n_q, valid_q, timeout_q;
    logic [DATA_W-1:0] data_q;

    // Bring the asynchronous end-of-conversion strobe into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoc_s1_q <= 1'b1;
            eoc_s2_q <= 1'b1;
            eoc_s3_q <= 1'b1;
        end else begin
            eoc_s1_q <= eoc_n_i;
            eoc_s2_q <= eoc_s1_q;
            eoc_s3_q <= eoc_s2_q;
        end
    end

    assign eoc_fall_w = eoc_s3_q && !eoc_s2_q;

    // Next-state decision for the conversion sequence.
    always_comb begin
        state_d   = state_q;
        timeout_d = 1'b0;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = ST_ACQ;
            ST_ACQ:     if (tmr_done) state_d = ST_SETUP;
            ST_SETUP:   if (tmr_done) state_d = ST_CONV;
            ST_CONV: begin
                if (eoc_fall_w) begin
                    state_d = ST_READ;
                end else if (tmr_done) begin
                    state_d   = ST_IDLE;
                    timeout_d = 1'b1;
                end
            end
            ST_READ:    if (tmr_done) state_d = ST_REL;
            ST_REL:     if (tmr_done) state_d = ST_PRESENT;
            ST_PRESENT: if (res_ready_i) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Interval to load on entry to each timed phase.
    always_comb begin
        tmr_load = (state_d != state_q);
        unique case (state_d)
            ST_ACQ:   tmr_val = TMR_W'(ACQ_CYC - 1);
            ST_SETUP: tmr_val = TMR_W'(SETUP_CYC - 1);
            ST_CONV:  tmr_val = TMR_W'(TIMEOUT_CYC - 1);
            ST_READ:  tmr_val = TMR_W'(RD_CYC - 1);
            ST_REL:   tmr_val = TMR_W'(REL_CYC - 1);
            default:  tmr_val = '0;
        endcase
    end

    adc_step_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    assign clk_go = (state_q == ST_SETUP) && tmr_done;
    assign clk_en = (state_d == ST_CONV);

    generate
        if (EXT_CLK) begin : g_ext_clk
            adc_conv_clk_gen #(.HALF_CYC(HALF_CYC), .N_PULSES(N_CONV_CLK)) u_clk_gen (
                .clk        (clk),
                .rst_n      (rst_n),
                .go         (clk_go),
                .en         (clk_en),
                .conv_clk_o (conv_clk_o)
            );
        end else begin : g_int_clk
            assign conv_clk_o = 1'b0;
        end
    endgenerate

    // State register and registered pin drives decoded from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q        <= ST_IDLE;
            conv_start_n_q <= 1'b1;
            cs_n_q         <= 1'b1;
            rd_n_q         <= 1'b1;
            valid_q        <= 1'b0;
            timeout_q      <= 1'b0;
        end else begin
            state_q        <= state_d;
            conv_start_n_q <= (state_d != ST_ACQ);
            cs_n_q         <= (state_d != ST_READ);
            rd_n_q         <= (state_d != ST_READ);
            valid_q        <= (state_d == ST_PRESENT);
            timeout_q      <= timeout_d;
        end
    end

    // Sample the bus on the final edge of the read window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (state_q == ST_READ && tmr_done) begin
            data_q <= data_i;
        end
    end

    assign conv_start_n_o = conv_start_n_q;
    assign cs_n_o         = cs_n_q;
    assign rd_n_o         = rd_n_q;
    assign res_data_o     = data_q;
    assign res_valid_o    = valid_q;
    assign timeout_o      = timeout_q;
    assign busy_o         = (state_q != ST_IDLE);

    // R10: the conversion clock is quiet while sampling or reading.
    p_clk_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv_start_n_o || !rd_n_o) |-> !conv_clk_o);

    // R4: a read strobe only opens after a detected end-of-conversion edge.
    p_read_after_eoc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n_o) |-> $past(eoc_fall_w));

    // R7: a waiting result holds until it is taken.
    p_hold_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_data_o)));

    // R9: a timeout leaves the block idle with no result.
    p_timeout_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (!busy_o && !res_valid_o));

    // R6: releasing the bus never coincides with a new acquisition.
    p_release_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_n_o) |=> (conv_start_n_o && cs_n_o));

endmodule

// File: tb/adc_conv_ctrl_bench.sv
module adc_conv_ctrl_bench;

    localparam int ACQ   = 8;
    localparam int SETUP = 2;
    localparam int HALF  = 3;
    localparam int NCLK  = 16;
    localparam int RD    = 3;
    localparam int REL   = 2;
    localparam int TOUT  = 200;

    // {word[22:9], ready delay[8:1], converter answers[0]}
    localparam logic [22:0] VECS [0:5] = '{
        {14'h0000, 8'd0, 1'b1},
        {14'h3FFF, 8'd0, 1'b1},
        {14'h2AAA, 8'd3, 1'b1},
        {14'h1555, 8'd1, 1'b1},
        {14'h0000, 8'd0, 1'b0},
        {14'h0001, 8'd5, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        convst_n, cclk, cs_n, rd_n, res_valid, timeout, busy;
    logic        eoc_n = 1'b1;
    logic        res_ready = 1'b0;
    logic [13:0] data_bus, res_data;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    logic [13:0] model_word = '0;
    logic        model_en = 1'b0;
    int          rdy_delay = 0;
    int          clr_tok = 0;
    int          spur_tok = 0;

    // monitor state (written only by the monitor process)
    int clr_seen = 0, spur_seen = 0;
    int fall_c, rise_c, first_rise_c, last_rise_c, last_fall_c;
    int n_fall, n_rise, n_cfall, bad_width, quiet_bad, csrd_bad;
    int rd_fall_c, rd_rise_c, n_rd, vrise_c, vfall_c, n_vrise, n_vfall;
    int data_bad, to_c, n_to, eoc_c, eoc_low_cnt, rdy_cnt;
    logic armed = 1'b0;
    logic p_convst = 1'b1, p_cclk = 1'b0, p_rd = 1'b1, p_valid = 1'b0, p_to = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign data_bus = !rd_n ? model_word : 14'h0000;

    adc_conv_ctrl u_adc_conv_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .conv_start_n_o(convst_n), .conv_clk_o(cclk),
        .cs_n_o(cs_n), .rd_n_o(rd_n), .eoc_n_i(eoc_n), .data_i(data_bus),
        .res_data_o(res_data), .res_valid_o(res_valid), .res_ready_i(res_ready),
        .timeout_o(timeout), .busy_o(busy)
    );

    // Monitor, converter model and host ready, all away from the active edge.
    always @(negedge clk) begin
        if (clr_tok != clr_seen) begin
            clr_seen = clr_tok;
            fall_c = 0; rise_c = 0; first_rise_c = 0; last_rise_c = 0; last_fall_c = 0;
            n_fall = 0; n_rise = 0; n_cfall = 0; bad_width = 0; quiet_bad = 0; csrd_bad = 0;
            rd_fall_c = 0; rd_rise_c = 0; n_rd = 0; vrise_c = 0; vfall_c = 0;
            n_vrise = 0; n_vfall = 0; data_bad = 0; to_c = 0; n_to = 0; eoc_c = 0;
            armed = 1'b1;
        end
        if (p_convst && !convst_n) begin fall_c = cyc; n_fall++; end
        if (!p_convst && convst_n) rise_c = cyc;
        if (!p_cclk && cclk) begin
            n_rise++;
            if (n_rise == 1) first_rise_c = cyc;
            else if (cyc - last_fall_c != HALF) bad_width++;
            last_rise_c = cyc;
        end
        if (p_cclk && !cclk) begin
            n_cfall++;
            if (cyc - last_rise_c != HALF) bad_width++;
            last_fall_c = cyc;
        end
        if (cclk && (!convst_n || !rd_n)) quiet_bad++;
        if (cs_n != rd_n) csrd_bad++;
        if (p_rd && !rd_n) begin rd_fall_c = cyc; n_rd++; end
        if (!p_rd && rd_n) rd_rise_c = cyc;
        if (!p_valid && res_valid) begin vrise_c = cyc; n_vrise++; end
        if (p_valid && !res_valid) begin vfall_c = cyc; n_vfall++; end
        if (res_valid && res_data != model_word) data_bad++;
        if (!p_to && timeout) begin to_c = cyc; n_to++; end
        p_convst = convst_n; p_cclk = cclk; p_rd = rd_n; p_valid = res_valid; p_to = timeout;

        if (eoc_low_cnt != 0) begin
            eoc_low_cnt--;
            if (eoc_low_cnt == 0) eoc_n = 1'b1;
        end else if (spur_tok != spur_seen) begin
            spur_seen = spur_tok;
            eoc_n = 1'b0; eoc_low_cnt = 6;
        end else if (model_en && armed && n_cfall == NCLK && !cclk) begin
            eoc_n = 1'b0; eoc_c = cyc; eoc_low_cnt = 6; armed = 1'b0;
        end

        if (res_valid && !res_ready) begin
            if (rdy_cnt == rdy_delay) res_ready = 1'b1;
            else rdy_cnt++;
        end else if (!res_valid) begin
            res_ready = 1'b0; rdy_cnt = 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic clear_mon();
        clr_tok++;
        @(negedge clk);
        step(1);
    endtask

    task automatic pulse_start();
        start = 1'b1;
        step(1);
        start = 1'b0;
    endtask

    task automatic run_vec(input logic [22:0] v);
        model_word = v[22:9];
        rdy_delay  = int'(v[8:1]);
        model_en   = v[0];
        clear_mon();
        pulse_start();
        step(3);
        pulse_start();                       // R8: request during acquisition
        step(45);
        pulse_start();                       // R8: request during clocking
        for (int w = 0; w < 1500; w++) begin
            if (n_vfall > 0 || n_to > 0) break;
            step(1);
        end
        step(4);
        chk(n_fall == 1, "R8 one start pulse", n_fall, 1);
        chk(rise_c - fall_c == ACQ, "R2 acquisition length", rise_c - fall_c, ACQ);
        chk(first_rise_c - rise_c == SETUP, "R3 setup gap", first_rise_c - rise_c, SETUP);
        chk(n_rise == NCLK, "R3 pulse count", n_rise, NCLK);
        chk(bad_width == 0, "R3 phase widths", bad_width, 0);
        chk(quiet_bad == 0, "R10 clock quiet", quiet_bad, 0);
        if (v[0]) begin
            chk(rd_fall_c - eoc_c == 3, "R4 eoc to read", rd_fall_c - eoc_c, 3);
            chk(rd_rise_c - rd_fall_c == RD, "R4 read width", rd_rise_c - rd_fall_c, RD);
            chk(csrd_bad == 0, "R4 cs with rd", csrd_bad, 0);
            chk(n_vrise == 1 && data_bad == 0, "R5 captured word", data_bad, 0);
            chk(vrise_c - rd_rise_c == REL, "R6 release gap", vrise_c - rd_rise_c, REL);
            chk(vfall_c - vrise_c == rdy_delay + 1, "R7 hold until ready",
                vfall_c - vrise_c, rdy_delay + 1);
        end else begin
            chk(to_c - first_rise_c == TOUT, "R9 timeout delay", to_c - first_rise_c, TOUT);
            chk(n_to == 1 && !timeout, "R9 single pulse", n_to, 1);
            chk(n_rd == 0 && n_vrise == 0, "R9 no read or result", n_rd + n_vrise, 0);
            chk(!busy, "R9 idle after timeout", busy, 0);
        end
    endtask

    function automatic int idle_pins();
        return {convst_n, cs_n, rd_n, cclk, res_valid, timeout, busy};
    endfunction

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_err + 1);
        $finish;
    end

    initial begin
        step(3);
        chk(idle_pins() == 7'b1110000, "R1 pins during reset", idle_pins(), 7'b1110000);
        rst_n = 1'b1;
        step(2);
        chk(idle_pins() == 7'b1110000, "R1 pins after reset", idle_pins(), 7'b1110000);

        for (int i = 0; i < 6; i++) run_vec(VECS[i]);

        // R4: end-of-conversion strobe while idle starts no read
        clear_mon();
        spur_tok++;
        step(12);
        chk(n_rd == 0 && !busy, "R4 idle strobe ignored", n_rd, 0);

        // R1: reset taken in the middle of the clock burst
        model_en = 1'b1;
        clear_mon();
        pulse_start();
        step(30);
        rst_n = 1'b0;
        step(2);
        chk(idle_pins() == 7'b1110000, "R1 mid-conversion reset", idle_pins(), 7'b1110000);
        rst_n = 1'b1;
        step(2);
        run_vec({14'h0ABC, 8'd2, 1'b1});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

endmodule